// File: doc/BRIEF.md
# Row-Scanned Pixel Array Readout Sequencer

This block produces the digital timing that reads out a sensor array organised as two identical halves of rows. Both halves are scanned together with one shared row index, and every half has a set of column banks that each serve eight columns through an 8-to-1 multiplexer. All banks move in lockstep, so a single column enable vector, a single multiplexer address and a single pair of sample/hold phases serve every bank in both halves.

For each visited row the sequencer walks through the selected columns. Every column slot follows a fixed pattern: the multiplexer address and column enable change while both sample/hold phases are low, a start-of-conversion strobe follows one cycle later, then the first sample/hold phase, a programmable gap, the second phase and another gap. The visited rows form a window given by a first row, a last row, a stride and a direction. Column decimation selects all columns, every other column or one column per bank. Configuration inputs are captured into shadow registers only when a frame begins, so a frame is always scanned with one consistent setting.

Top module: `pix_scan_seq`

## Requirements
- R1: During reset and in the cycle after `run` is sampled low, `sh_s1`, `sh_s2`, `conv_start`, `frame_start`, `row_start` and `col_en` are all 0; in reset `row_addr` and `mux_addr` are 0.
- R2: When `run` is sampled high while idle, the next cycle is the first slot of a frame: `frame_start` and `row_start` are 1 and `row_addr` equals the configured first row.
- R3: A column slot lasts 4+2D cycles, D being `cfg_gap` with 0 treated as 1: cycle 0 address, cycle 1 `conv_start`, cycle 2 `sh_s1`, D gap cycles, one `sh_s2` cycle, D gap cycles; each strobe is high in exactly its one cycle.
- R4: `sh_s1` and `sh_s2` are never high together and at least one cycle with both low separates a fall of one from a rise of the other.
- R5: `mux_addr` changes only at the start of a slot, in a cycle where both phases are low and were low in the previous cycle; `conv_start` is high exactly one cycle after that change.
- R6: During a scan `col_en` is one-hot with bit `mux_addr` set (bit i selects column i of every bank); it is 0 when idle.
- R7: `cfg_decim` 0 or 3 visits columns 0..7 in ascending order, 1 visits 0,2,4,6, 2 visits only column 0.
- R8: Rows advance by `cfg_stride` (0 treated as 1), upward when `cfg_down`=0 and downward when 1; `row_start` pulses in the first slot of every row and `row_addr` changes only there.
- R9: When the next row would lie past the last row in the scan direction, the scan returns to the first row and `frame_start` pulses for one cycle with `row_start`.
- R10: If the first row lies past the last row for the chosen direction, every frame consists of the first row alone.
- R11: Changes to the configuration inputs during a frame do not affect that frame; they apply from the next frame start.
- R12: A first or last row above 53 (rows per half minus one) is treated as 53.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scan enable; low aborts to idle |
| cfg_first | input | 6 | First row of the window |
| cfg_last | input | 6 | Last row of the window |
| cfg_stride | input | 6 | Row stride, 0 means 1 |
| cfg_down | input | 1 | Scan direction, 1 = decreasing rows |
| cfg_decim | input | 2 | Column decimation mode |
| cfg_gap | input | 4 | Dead time between phases in cycles, 0 means 1 |
| row_addr | output | 6 | Row index shared by both halves |
| col_en | output | 8 | One-hot column buffer enable within each bank |
| mux_addr | output | 3 | Bank multiplexer address |
| sh_s1 | output | 1 | First sample/hold phase |
| sh_s2 | output | 1 | Second sample/hold phase |
| conv_start | output | 1 | Start-of-conversion strobe |
| frame_start | output | 1 | First slot of a frame |
| row_start | output | 1 | First slot of a row |

## Verification
A wrong phase state or gap count shows at the ports within one slot as a strobe in the wrong cycle or a slot of the wrong length, which breaks the cycle-accurate comparison immediately. A wrong column counter or decimation stride shows as a wrong `mux_addr`/`col_en` at the next slot boundary, and a wrong row stepping, wrap or shadow capture shows at the next row or frame boundary as an unexpected `row_addr`, a missing or extra `frame_start`, or a frame scanned with freshly written settings.

// File: rtl/pss_pkg.sv
package pss_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_SOC  = 3'd2,
    PH_S1   = 3'd3,
    PH_GAP1 = 3'd4,
    PH_S2   = 3'd5,
    PH_GAP2 = 3'd6
  } ph_t;

  typedef enum logic [1:0] {
    DEC_ALL   = 2'd0,
    DEC_HALF  = 2'd1,
    DEC_EIGHT = 2'd2,
    DEC_RSVD  = 2'd3
  } decim_t;

endpackage

// File: rtl/pss_phase_fsm.sv
module pss_phase_fsm
  import pss_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [GAP_W-1:0] gap,
  output ph_t              ph,
  output logic             slot_end
);

  ph_t              ph_q, ph_d;
  logic [GAP_W-1:0] cnt_q, cnt_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_SOC;
      PH_SOC:  ph_d = PH_S1;
      PH_S1: begin
        ph_d  = PH_GAP1;
        cnt_d = gap - GAP_W'(1);
      end
      PH_GAP1: begin
        if (cnt_q == '0) ph_d = PH_S2;
        else             cnt_d = cnt_q - GAP_W'(1);
      end
      PH_S2: begin
        ph_d  = PH_GAP2;
        cnt_d = gap - GAP_W'(1);
      end
      PH_GAP2: begin
        if (cnt_q == '0) ph_d = PH_ADDR;
        else             cnt_d = cnt_q - GAP_W'(1);
      end
      default: ph_d = PH_IDLE;
    endcase
    if (!run) ph_d = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign ph       = ph_q;
  assign slot_end = (ph_q == PH_GAP2) && (cnt_q == '0);

  // S2 is only ever entered from the first gap (R4)
  assert_s2_after_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_S2) |-> ($past(ph_q) == PH_GAP1));

  // conversion strobe always follows the address cycle (R5)
  assert_soc_after_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SOC) |-> ($past(ph_q) == PH_ADDR));

endmodule

// File: rtl/pss_col_ctr.sv
module pss_col_ctr
  import pss_pkg::*;
#(
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    active,
  input  logic                    clr,
  input  logic                    adv,
  input  decim_t                  decim,
  output logic [$clog2(COLS)-1:0] col,
  output logic                    last
);

  localparam int CW = $clog2(COLS);

  logic [CW-1:0] col_q, col_d;
  logic [CW:0]   stride, sum;

  always_comb begin
    unique case (decim)
      DEC_HALF:  stride = (CW+1)'(2);
      DEC_EIGHT: stride = (CW+1)'(COLS);
      default:   stride = (CW+1)'(1);
    endcase
    sum   = {1'b0, col_q} + stride;
    last  = sum >= (CW+1)'(COLS);
    col_d = clr ? '0 : sum[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          col_q <= '0;
    else if (clr || adv) col_q <= col_d;
  end

  assign col = col_q;

  // one-in-eight mode never leaves column 0 (R7)
  assert_eighth_col0_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && decim == DEC_EIGHT) |-> (col_q == '0));

endmodule

// File: rtl/pss_row_ctr.sv
module pss_row_ctr #(
  parameter int ROWS = 54
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [$clog2(ROWS)-1:0] load_val,
  input  logic                    adv,
  input  logic [$clog2(ROWS)-1:0] stride,
  input  logic [$clog2(ROWS)-1:0] last_row,
  input  logic                    down,
  output logic [$clog2(ROWS)-1:0] row,
  output logic                    wrap
);

  localparam int RW = $clog2(ROWS);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

  logic [RW-1:0] row_q, row_d;
  logic [RW:0]   up_sum;

  always_comb begin
    up_sum = {1'b0, row_q} + {1'b0, stride};
    if (down) begin
      wrap  = (row_q < stride) || ((row_q - stride) < last_row);
      row_d = row_q - stride;
    end else begin
      wrap  = up_sum > {1'b0, last_row};
      row_d = up_sum[RW-1:0];
    end
    if (load) row_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           row_q <= '0;
    else if (load || adv) row_q <= row_d;
  end

  assign row = row_q;

  assert_row_range_R12: assert property (@(posedge clk) disable iff (!rst_n)
    row_q <= ROW_MAX);

endmodule

// File: rtl/pix_scan_seq.sv
module pix_scan_seq
  import pss_pkg::*;
#(
  parameter int ROWS  = 54,
  parameter int COLS  = 8,
  parameter int GAP_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run,
  input  logic [$clog2(ROWS)-1:0] cfg_first,
  input  logic [$clog2(ROWS)-1:0] cfg_last,
  input  logic [$clog2(ROWS)-1:0] cfg_stride,
  input  logic                    cfg_down,
  input  logic [1:0]              cfg_decim,
  input  logic [GAP_W-1:0]        cfg_gap,
  output logic [$clog2(ROWS)-1:0] row_addr,
  output logic [COLS-1:0]         col_en,
  output logic [$clog2(COLS)-1:0] mux_addr,
  output logic                    sh_s1,
  output logic                    sh_s2,
  output logic                    conv_start,
  output logic                    frame_start,
  output logic                    row_start
);

  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(COLS);
  localparam logic [RW-1:0] ROW_MAX = RW'(ROWS - 1);

  ph_t              ph;
  logic             slot_end, active, start, slot_adv;
  logic             col_last, row_wrap, row_end, frame_load, row_adv;
  logic [CW-1:0]    col;
  logic [RW-1:0]    first_clamp, last_clamp, stride_norm;
  logic [GAP_W-1:0] gap_norm;

  // shadow configuration, captured at frame boundaries only
  logic [RW-1:0]    shd_last, shd_stride;
  logic             shd_down;
  decim_t           shd_decim;
  logic [GAP_W-1:0] shd_gap;
  logic             frm_q, rowp_q;

  always_comb begin
    first_clamp = (cfg_first > ROW_MAX) ? ROW_MAX : cfg_first;
    last_clamp  = (cfg_last  > ROW_MAX) ? ROW_MAX : cfg_last;
    stride_norm = (cfg_stride == '0) ? RW'(1) : cfg_stride;
    gap_norm    = (cfg_gap == '0) ? GAP_W'(1) : cfg_gap;
    active      = (ph != PH_IDLE);
    start       = run && !active;
    slot_adv    = run && slot_end;
    row_end     = slot_adv && col_last;
    frame_load  = start || (row_end && row_wrap);
    row_adv     = row_end && !row_wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_last   <= '0;
      shd_stride <= RW'(1);
      shd_down   <= 1'b0;
      shd_decim  <= DEC_ALL;
      shd_gap    <= GAP_W'(1);
    end else if (frame_load) begin
      shd_last   <= last_clamp;
      shd_stride <= stride_norm;
      shd_down   <= cfg_down;
      shd_decim  <= decim_t'(cfg_decim);
      shd_gap    <= gap_norm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q  <= 1'b0;
      rowp_q <= 1'b0;
    end else begin
      frm_q  <= frame_load;
      rowp_q <= frame_load || row_adv;
    end
  end

  pss_phase_fsm #(.GAP_W(GAP_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .gap(shd_gap),
    .ph(ph), .slot_end(slot_end)
  );

  pss_col_ctr #(.COLS(COLS)) u_col (
    .clk(clk), .rst_n(rst_n), .active(active),
    .clr(frame_load || row_adv), .adv(slot_adv && !col_last),
    .decim(shd_decim), .col(col), .last(col_last)
  );

  pss_row_ctr #(.ROWS(ROWS)) u_row (
    .clk(clk), .rst_n(rst_n), .load(frame_load), .load_val(first_clamp),
    .adv(row_adv), .stride(shd_stride), .last_row(shd_last), .down(shd_down),
    .row(row_addr), .wrap(row_wrap)
  );

  assign mux_addr    = col;
  assign col_en      = active ? ({{(COLS-1){1'b0}}, 1'b1} << col) : '0;
  assign sh_s1       = (ph == PH_S1);
  assign sh_s2       = (ph == PH_S2);
  assign conv_start  = (ph == PH_SOC);
  assign frame_start = frm_q;
  assign row_start   = rowp_q;

  assert_gap_s1_s2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_s2) |-> !$past(sh_s1));

  assert_gap_s2_s1_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sh_s1) |-> !$past(sh_s2));

  assert_mux_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_addr) |-> (!sh_s1 && !sh_s2 && !$past(sh_s1) && !$past(sh_s2)));

  assert_col_on_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sh_s1 |-> $onehot(col_en));

  assert_row_moves_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$stable(row_addr)) |-> row_start);

  assert_frame_with_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (row_start && !$past(frame_start)));

endmodule

// File: tb/tb_pix_scan_seq.sv
`timescale 1ns/1ps
module tb_pix_scan_seq;

  logic       clk, rst_n, run;
  logic [5:0] cfg_first, cfg_last, cfg_stride;
  logic       cfg_down;
  logic [1:0] cfg_decim;
  logic [3:0] cfg_gap;
  logic [5:0] row_addr;
  logic [7:0] col_en;
  logic [2:0] mux_addr;
  logic       sh_s1, sh_s2, conv_start, frame_start, row_start;

  int    n_chk = 0;
  int    n_fail = 0;
  int    last_rows = 0;
  string ctx = "reset";

  pix_scan_seq dut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_first(cfg_first), .cfg_last(cfg_last), .cfg_stride(cfg_stride),
    .cfg_down(cfg_down), .cfg_decim(cfg_decim), .cfg_gap(cfg_gap),
    .row_addr(row_addr), .col_en(col_en), .mux_addr(mux_addr),
    .sh_s1(sh_s1), .sh_s2(sh_s2), .conv_start(conv_start),
    .frame_start(frame_start), .row_start(row_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s (%s) actual=%0d expected=%0d", tag, ctx, act, exp);
    end
  endtask

  function automatic int clampr(int v);
    return (v > 53) ? 53 : v;
  endfunction

  task automatic set_cfg(int f, int l, int s, int d, int m, int g);
    cfg_first = 6'(f); cfg_last = 6'(l); cfg_stride = 6'(s);
    cfg_down = 1'(d); cfg_decim = 2'(m); cfg_gap = 4'(g);
  endtask

  task automatic rand_cfg();
    set_cfg($urandom_range(0, 57), $urandom_range(0, 57), $urandom_range(0, 6),
            $urandom_range(0, 1), $urandom_range(0, 3), $urandom_range(0, 3));
  endtask

  task automatic chk_idle();
    chk(!sh_s1 && !sh_s2 && !conv_start, "R1 phases", {sh_s1, sh_s2, conv_start}, 0);
    chk(!frame_start && !row_start, "R1 markers", {frame_start, row_start}, 0);
    chk(col_en == 8'd0, "R1 col_en", col_en, 0);
  endtask

  // one counted check per slot; compares every output in every cycle
  task automatic check_slot(int row, int col, bit fs, bit rs, int d, bit chg);
    bit    bad = 0;
    string tag = "";
    int    a = 0, e = 0;
    int    n = 4 + 2 * d;
    for (int k = 0; k < n; k++) begin
      if (!bad) begin
        if (row_addr != 6'(row))                     begin bad = 1; tag = "R8 row";       a = row_addr;    e = row; end
        else if (mux_addr != 3'(col))                begin bad = 1; tag = "R7 mux";       a = mux_addr;    e = col; end
        else if (col_en != (8'd1 << col))            begin bad = 1; tag = "R6 col_en";    a = col_en;      e = 1 << col; end
        else if (conv_start != (k == 1))             begin bad = 1; tag = "R5 conv";      a = conv_start;  e = (k == 1); end
        else if (sh_s1 != (k == 2))                  begin bad = 1; tag = "R3 s1";        a = sh_s1;       e = (k == 2); end
        else if (sh_s2 != (k == 3 + d))              begin bad = 1; tag = "R3 s2";        a = sh_s2;       e = (k == 3 + d); end
        else if (sh_s1 && sh_s2)                     begin bad = 1; tag = "R4 overlap";   a = 1;           e = 0; end
        else if (frame_start != (fs && k == 0))      begin bad = 1; tag = "R9 frame";     a = frame_start; e = fs && k == 0; end
        else if (row_start != (rs && k == 0))        begin bad = 1; tag = "R8 row_start"; a = row_start;   e = rs && k == 0; end
        if (bad) tag = $sformatf("%s k=%0d", tag, k);
      end
      if (chg && k == 1) rand_cfg();
      @(negedge clk);
    end
    chk(!bad, tag, a, e);
  endtask

  // checks one whole frame against the settings present at its start
  task automatic check_frame(bit chg);
    int f = clampr(int'(cfg_first));
    int l = clampr(int'(cfg_last));
    int s = (cfg_stride == 0) ? 1 : int'(cfg_stride);
    bit dn = cfg_down;
    int cs = (cfg_decim == 2'd1) ? 2 : (cfg_decim == 2'd2) ? 8 : 1;
    int d = (cfg_gap == 0) ? 1 : int'(cfg_gap);
    int row = f;
    bit first = 1;
    int nr;
    last_rows = 0;
    while (1) begin
      last_rows++;
      for (int c = 0; c < 8; c += cs) begin
        check_slot(row, c, first, c == 0, d, chg && first);
        first = 0;
      end
      nr = dn ? row - s : row + s;
      if (dn ? (nr < l) : (nr > l)) break;
      row = nr;
    end
  endtask

  task automatic restart(int exp_row);
    run = 1'b0;
    @(negedge clk);
    chk_idle();
    run = 1'b1;
    @(negedge clk);
    chk(frame_start == 1'b1, "R2 frame_start", frame_start, 1);
    chk(row_addr == 6'(exp_row), "R2 first row", row_addr, exp_row);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog (%s) actual=%0d expected=%0d", ctx, 190000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; run = 1'b0;
    set_cfg(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    ctx = "reset";
    chk_idle();
    chk(row_addr == 6'd0 && mux_addr == 3'd0, "R1 addr", {row_addr, mux_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle();

    ctx = "up window, half decimation, gap 0";
    set_cfg(3, 7, 2, 0, 1, 0);
    restart(3);
    check_frame(0);
    ctx = "R9 wrap to first row";
    check_frame(0);

    ctx = "R8 down stride 3, one in eight";
    set_cfg(20, 10, 3, 1, 2, 2);
    restart(20);
    check_frame(0);
    check_frame(0);

    ctx = "R7 all columns, reserved code";
    set_cfg(30, 31, 1, 0, 3, 1);
    restart(30);
    check_frame(0);

    ctx = "R10 collapse up";
    set_cfg(9, 4, 1, 0, 2, 1);
    restart(9);
    check_frame(0);
    chk(last_rows == 1, "R10 rows up", last_rows, 1);
    ctx = "R10 collapse down";
    set_cfg(4, 9, 1, 1, 2, 1);
    restart(4);
    check_frame(0);
    chk(last_rows == 1, "R10 rows down", last_rows, 1);

    ctx = "R12 clamp first";
    set_cfg(60, 63, 1, 0, 2, 1);
    restart(53);
    check_frame(0);
    chk(last_rows == 1, "R12 rows", last_rows, 1);
    ctx = "R12 clamp last";
    set_cfg(50, 63, 0, 0, 2, 1);
    restart(50);
    check_frame(0);
    chk(last_rows == 4, "R12 rows", last_rows, 4);

    ctx = "R11 mid-frame rewrite";
    set_cfg(2, 5, 1, 0, 2, 1);
    restart(2);
    check_frame(1);
    ctx = "R11 new settings applied";
    check_frame(0);

    ctx = "R1 abort mid-slot";
    repeat (2) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    chk_idle();

    ctx = "random";
    rand_cfg();
    restart(clampr(int'(cfg_first)));
    for (int i = 0; i < 14; i++) begin
      check_frame(1'($urandom_range(0, 1)));
    end

    finish_run();
  end

endmodule